// File: doc/BRIEF.md
# Per-Bank Addressed Vector Register File

This block is a wide vector register file whose entries are cut into byte-wide banks, and each bank takes its own entry address on every port. A single access can therefore gather bytes from many different entries into one output vector, or scatter the bytes of one input vector across many entries. Column, diagonal, chessboard and stride patterns all come from this vertical shuffle without a separate permute stage. Three read ports and one write port all work in the same clock cycle.

Each port picks where its per-bank addresses come from. It can send one entry number to every bank. It can take a packed vector of 5-bit bank addresses from the port. It can also take the addresses from the low bits of the bytes of an entry already held in the file. A width code makes groups of 2, 4 or 8 adjacent banks share the lead bank's address, so 16-, 32- and 64-bit lanes move as a unit. A read port can also blend two entries, taking each byte from one of them under a byte mask. Per-byte enables stop unused banks from switching: a disabled read byte returns zero and a disabled write byte keeps its value.

Top module: `vreg_gather_rf`

## Requirements
- R1: With the defaults, the file holds 32 entries of 32 bytes. The three read ports and the write port each take a request on every clock edge, and the ports do not affect one another.
- R2: A read request sampled at a clock edge drives its result on rd_data_o from that edge until the next one. Data written at an edge can be read by a request sampled at the following edge.
- R3: If a read and the write address the same bank and entry at the same edge, the read returns the value held before the write.
- R4: Address mode 0 (row) sends rd_row_i (or wr_row_i) to every bank.
- R5: Address mode 1 (vector) gives bank i the address in bits [5i+4:5i] of the port's address vector.
- R6: Address mode 2 (pointer) gives bank i bits [4:0] of byte i of the entry named by the port's row input, and ignores bits [7:5] of that byte. For a write, the pointer entry is read before that cycle's write.
- R7: In modes 1 and 2, width code w (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) makes bank i use the address that the rules give bank i rounded down to a multiple of 2^w.
- R8: A read byte whose enable is low returns 0x00.
- R9: A write byte whose enable is low leaves every entry of that bank unchanged.
- R10: Read address mode 3 (blend) gives byte i from entry rd_alt_i when mask bit i is 1, and from entry rd_row_i when it is 0. The read byte enables still apply.
- R11: Write address mode 3 behaves like write mode 0.
- R12: An active reset clears every entry and every read output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | NUM_RD x NUM_BANKS | Per-port, per-byte read enables |
| rd_mode_i | input | NUM_RD x 2 | Read address mode: 0 row, 1 vector, 2 pointer, 3 blend |
| rd_width_i | input | NUM_RD x 2 | Read lane width code for modes 1 and 2 |
| rd_row_i | input | NUM_RD x AW | Row entry, pointer entry, or first blend entry |
| rd_alt_i | input | NUM_RD x AW | Second blend entry |
| rd_mask_i | input | NUM_RD x NUM_BANKS | Blend byte mask (1 selects rd_alt_i) |
| rd_vec_i | input | NUM_RD x NUM_BANKS x AW | Per-bank read address vector |
| rd_data_o | output | NUM_RD x NUM_BANKS x 8 | Registered read data |
| wr_en_i | input | NUM_BANKS | Per-byte write enables |
| wr_mode_i | input | 2 | Write address mode: 0 row, 1 vector, 2 pointer, 3 as 0 |
| wr_width_i | input | 2 | Write lane width code for modes 1 and 2 |
| wr_row_i | input | AW | Row entry or pointer entry for the write |
| wr_vec_i | input | NUM_BANKS x AW | Per-bank write address vector |
| wr_data_i | input | NUM_BANKS x 8 | Write data |

## Verification
The assertions check three things on every cycle: a disabled read byte comes out as zero one edge later, a bank whose write enable is low keeps all of its entries, and a full-row write can be read back by a full-row read one edge later. They also compare a zero-mask blend on port 1 with a plain row read of the same entry on port 0. Only the bench scenarios can show the address arithmetic itself. These are the gather and scatter patterns in every lane width, the pointer mode with junk in the upper bits of its pointer bytes (including a write that lands on its own pointer entry), the read-before-write ordering, and blends under arbitrary masks. They are checked against a byte-level model of the storage.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    AM_ROW   = 2'd0,
    AM_EXT   = 2'd1,
    AM_PTR   = 2'd2,
    AM_BLEND = 2'd3
  } amode_e;
endpackage

// File: rtl/vrf_bank.sv
module vrf_bank
  import vrf_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int AW          = $clog2(NUM_ENTRIES)
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   we_i,
  input  logic [AW-1:0]                          waddr_i,
  input  logic [BYTE_W-1:0]                      wdata_i,
  output logic [NUM_ENTRIES-1:0][BYTE_W-1:0]     col_o
);
  logic [NUM_ENTRIES-1:0]             wsel;
  logic [NUM_ENTRIES-1:0][BYTE_W-1:0] col_q;

  // one-hot word select
  assign wsel = we_i ? (NUM_ENTRIES'(1) << waddr_i) : '0;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      col_q[e] <= '0;
      else if (wsel[e]) col_q[e] <= wdata_i;
    end
  end

  assign col_o = col_q;

  assert_wr_off_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(col_o))
    else $error("R9: bank changed with write disabled");
endmodule

// File: rtl/vrf_addr_gen.sv
module vrf_addr_gen
  import vrf_pkg::*;
#(
  parameter int NUM_BANKS = 32,
  parameter int AW        = 5,
  parameter int BIDX      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [1:0]                    mode_i,
  input  logic [1:0]                    width_i,
  input  logic [AW-1:0]                 row_i,
  input  logic [NUM_BANKS-1:0][AW-1:0]  vec_i,
  input  logic [NUM_BANKS-1:0][AW-1:0]  ptr_i,
  output logic [NUM_BANKS-1:0][AW-1:0]  addr_o
);
  amode_e                        mode;
  logic [NUM_BANKS-1:0][AW-1:0]  base;
  logic [BIDX-1:0]               grp_mask;

  assign mode     = amode_e'(mode_i);
  assign grp_mask = ~((BIDX'(1) << width_i) - BIDX'(1));

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      case (mode)
        AM_EXT:  base[b] = vec_i[b];
        AM_PTR:  base[b] = ptr_i[b];
        default: base[b] = row_i;
      endcase
    end
  end

  // lane grouping: every bank follows the lead bank of its group
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      addr_o[b] = base[BIDX'(b) & grp_mask];
    end
  end
endmodule

// File: rtl/vrf_rd_port.sv
module vrf_rd_port
  import vrf_pkg::*;
#(
  parameter int NUM_BANKS   = 32,
  parameter int NUM_ENTRIES = 32,
  parameter int AW          = $clog2(NUM_ENTRIES)
) (
  input  logic                                                clk_i,
  input  logic                                                rst_ni,
  input  logic [NUM_BANKS-1:0]                                en_i,
  input  logic [1:0]                                          mode_i,
  input  logic [1:0]                                          width_i,
  input  logic [AW-1:0]                                       row_i,
  input  logic [AW-1:0]                                       alt_i,
  input  logic [NUM_BANKS-1:0]                                mask_i,
  input  logic [NUM_BANKS-1:0][AW-1:0]                        vec_i,
  input  logic [NUM_BANKS-1:0][NUM_ENTRIES-1:0][BYTE_W-1:0]   bank_i,
  output logic [NUM_BANKS-1:0][BYTE_W-1:0]                    data_o
);
  logic [NUM_BANKS-1:0][AW-1:0]     ptr_addr;
  logic [NUM_BANKS-1:0][AW-1:0]     bank_addr;
  logic [NUM_BANKS-1:0][AW-1:0]     sel_addr;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] data_d;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] data_q;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      ptr_addr[b] = bank_i[b][row_i][AW-1:0];
    end
  end

  vrf_addr_gen #(
    .NUM_BANKS (NUM_BANKS),
    .AW        (AW)
  ) u_agen (
    .mode_i  (mode_i),
    .width_i (width_i),
    .row_i   (row_i),
    .vec_i   (vec_i),
    .ptr_i   (ptr_addr),
    .addr_o  (bank_addr)
  );

  // blend picks the alternate entry per byte; disabled bytes read zero
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      sel_addr[b] = (mode_i == AM_BLEND && mask_i[b]) ? alt_i : bank_addr[b];
      data_d[b]   = en_i[b] ? bank_i[b][sel_addr[b]] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    assert_rd_off_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[b] |=> (data_o[b] == '0))
      else $error("R8: disabled read byte not zero");
  end
endmodule

// File: rtl/vreg_gather_rf.sv
module vreg_gather_rf
  import vrf_pkg::*;
#(
  parameter  int NUM_ENTRIES = 32,
  parameter  int NUM_BANKS   = 32,
  parameter  int NUM_RD      = 3,
  localparam int AW          = $clog2(NUM_ENTRIES)
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic [NUM_RD-1:0][NUM_BANKS-1:0]             rd_en_i,
  input  logic [NUM_RD-1:0][1:0]                       rd_mode_i,
  input  logic [NUM_RD-1:0][1:0]                       rd_width_i,
  input  logic [NUM_RD-1:0][AW-1:0]                    rd_row_i,
  input  logic [NUM_RD-1:0][AW-1:0]                    rd_alt_i,
  input  logic [NUM_RD-1:0][NUM_BANKS-1:0]             rd_mask_i,
  input  logic [NUM_RD-1:0][NUM_BANKS-1:0][AW-1:0]     rd_vec_i,
  output logic [NUM_RD-1:0][NUM_BANKS-1:0][BYTE_W-1:0] rd_data_o,
  input  logic [NUM_BANKS-1:0]                         wr_en_i,
  input  logic [1:0]                                   wr_mode_i,
  input  logic [1:0]                                   wr_width_i,
  input  logic [AW-1:0]                                wr_row_i,
  input  logic [NUM_BANKS-1:0][AW-1:0]                 wr_vec_i,
  input  logic [NUM_BANKS-1:0][BYTE_W-1:0]             wr_data_i
);
  logic [NUM_BANKS-1:0][NUM_ENTRIES-1:0][BYTE_W-1:0] bank_q;
  logic [1:0]                                        wr_mode_eff;
  logic [NUM_BANKS-1:0][AW-1:0]                      wr_ptr;
  logic [NUM_BANKS-1:0][AW-1:0]                      wr_addr;

  // blend has no meaning on the write side
  assign wr_mode_eff = (wr_mode_i == AM_BLEND) ? AM_ROW : wr_mode_i;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      wr_ptr[b] = bank_q[b][wr_row_i][AW-1:0];
    end
  end

  vrf_addr_gen #(
    .NUM_BANKS (NUM_BANKS),
    .AW        (AW)
  ) u_wr_agen (
    .mode_i  (wr_mode_eff),
    .width_i (wr_width_i),
    .row_i   (wr_row_i),
    .vec_i   (wr_vec_i),
    .ptr_i   (wr_ptr),
    .addr_o  (wr_addr)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vrf_bank #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .AW          (AW)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i[b]),
      .waddr_i (wr_addr[b]),
      .wdata_i (wr_data_i[b]),
      .col_o   (bank_q[b])
    );
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    vrf_rd_port #(
      .NUM_BANKS   (NUM_BANKS),
      .NUM_ENTRIES (NUM_ENTRIES),
      .AW          (AW)
    ) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (rd_en_i[p]),
      .mode_i  (rd_mode_i[p]),
      .width_i (rd_width_i[p]),
      .row_i   (rd_row_i[p]),
      .alt_i   (rd_alt_i[p]),
      .mask_i  (rd_mask_i[p]),
      .vec_i   (rd_vec_i[p]),
      .bank_i  (bank_q),
      .data_o  (rd_data_o[p])
    );
  end

  // full-row write is visible to a full-row read one edge later
  assert_wr_then_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i == '1) && $past(wr_mode_i == AM_ROW) &&
     rd_mode_i[0] == AM_ROW && rd_en_i[0] == '1 && rd_row_i[0] == $past(wr_row_i))
    |=> (rd_data_o[0] == $past(wr_data_i, 2)))
    else $error("R2: row write not returned by following read");

  if (NUM_RD > 1) begin : g_blend_chk
    assert_blend_zero_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_mode_i[0] == AM_ROW && rd_mode_i[1] == AM_BLEND && rd_mask_i[1] == '0 &&
       rd_row_i[0] == rd_row_i[1] && rd_en_i[0] == rd_en_i[1])
      |=> (rd_data_o[1] == rd_data_o[0]))
      else $error("R10: zero-mask blend differs from row read");
  end
endmodule

// File: tb/tb_vreg_gather_rf.sv
module tb_vreg_gather_rf;
  localparam int NE  = 32;
  localparam int NB  = 32;
  localparam int NRD = 3;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [NRD-1:0][NB-1:0]          rd_en;
  logic [NRD-1:0][1:0]             rd_mode;
  logic [NRD-1:0][1:0]             rd_width;
  logic [NRD-1:0][AW-1:0]          rd_row;
  logic [NRD-1:0][AW-1:0]          rd_alt;
  logic [NRD-1:0][NB-1:0]          rd_mask;
  logic [NRD-1:0][NB-1:0][AW-1:0]  rd_vec;
  logic [NRD-1:0][NB-1:0][7:0]     rd_data;
  logic [NB-1:0]                   wr_en;
  logic [1:0]                      wr_mode;
  logic [1:0]                      wr_width;
  logic [AW-1:0]                   wr_row;
  logic [NB-1:0][AW-1:0]           wr_vec;
  logic [NB-1:0][7:0]              wr_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0]  mem [NE][NB];
  logic [31:0] rs = 32'h2468ace1;

  vreg_gather_rf dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rd_en_i    (rd_en),
    .rd_mode_i  (rd_mode),
    .rd_width_i (rd_width),
    .rd_row_i   (rd_row),
    .rd_alt_i   (rd_alt),
    .rd_mask_i  (rd_mask),
    .rd_vec_i   (rd_vec),
    .rd_data_o  (rd_data),
    .wr_en_i    (wr_en),
    .wr_mode_i  (wr_mode),
    .wr_width_i (wr_width),
    .wr_row_i   (wr_row),
    .wr_vec_i   (wr_vec),
    .wr_data_i  (wr_data)
  );

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  // bank address from the mode rules (R4..R7, R10)
  function automatic logic [AW-1:0] pick(int b, logic [1:0] mode, logic [1:0] w,
                                         logic [AW-1:0] row, logic [AW-1:0] alt,
                                         logic mbit, logic [NB-1:0][AW-1:0] vec);
    int ld;
    ld = (b / (1 << w)) * (1 << w);
    case (mode)
      2'd1:    return vec[ld];
      2'd2:    return mem[row][ld][AW-1:0];
      2'd3:    return mbit ? alt : row;
      default: return row;
    endcase
  endfunction

  task automatic check(string tag, logic [8*NB-1:0] act, logic [8*NB-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    rd_en = '0; rd_mode = '0; rd_width = '0; rd_row = '0; rd_alt = '0;
    rd_mask = '0; rd_vec = '0;
    wr_en = '0; wr_mode = '0; wr_width = '0; wr_row = '0; wr_vec = '0; wr_data = '0;
  endtask

  task automatic rand_wdata();
    for (int b = 0; b < NB; b++) begin
      logic [31:0] r;
      r = rnd();
      wr_data[b] = r[7:0];
    end
  endtask

  task automatic row_reads(int r0, int r1, int r2);
    rd_mode = '0; rd_en = '1;
    rd_row[0] = AW'(r0); rd_row[1] = AW'(r1); rd_row[2] = AW'(r2);
  endtask

  // one clock: predict from the model (reads see pre-write state, R3), then compare
  task automatic step(string tag);
    logic [NRD-1:0][NB-1:0][7:0] exp;
    logic [NB-1:0][AW-1:0]       wa;
    logic [1:0]                  wm;
    for (int p = 0; p < NRD; p++)
      for (int b = 0; b < NB; b++)
        exp[p][b] = rd_en[p][b] ?
          mem[pick(b, rd_mode[p], rd_width[p], rd_row[p], rd_alt[p], rd_mask[p][b], rd_vec[p])][b]
          : 8'h00;
    wm = (wr_mode == 2'd3) ? 2'd0 : wr_mode;  // R11
    for (int b = 0; b < NB; b++) wa[b] = pick(b, wm, wr_width, wr_row, '0, 1'b0, wr_vec);
    for (int b = 0; b < NB; b++) if (wr_en[b]) mem[wa[b]][b] = wr_data[b];
    @(negedge clk);
    for (int p = 0; p < NRD; p++) check($sformatf("%s port%0d", tag, p), rd_data[p], exp[p]);
  endtask

  task automatic readback_all(string tag);
    clear_in();
    for (int e = 0; e < NE; e++) begin
      row_reads(e, NE - 1 - e, (e + 11) % NE);
      step(tag);
    end
  endtask

  initial begin
    for (int e = 0; e < NE; e++) for (int b = 0; b < NB; b++) mem[e][b] = 8'h00;
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NRD; p++) check($sformatf("R12 reset out port%0d", p), rd_data[p], '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: storage empty after reset
    row_reads(0, 13, 31); step("R12 cleared");
    row_reads(7, 21, 2);  step("R12 cleared");

    // R4: uniform fill while reading other rows
    for (int e = 0; e < NE; e++) begin
      wr_en = '1; wr_mode = 2'd0; wr_row = AW'(e); rand_wdata();
      row_reads((e + 3) % NE, (e * 5) % NE, NE - 1 - e);
      step("R4 fill");
    end
    readback_all("R1 readback");

    // R5/R7: gather patterns in every lane width
    clear_in();
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 6; k++) begin
        for (int p = 0; p < NRD; p++) begin
          rd_mode[p] = 2'd1; rd_width[p] = 2'(w); rd_en[p] = '1;
          for (int b = 0; b < NB; b++) begin
            logic [31:0] r;
            r = rnd();
            case (k)
              0: rd_vec[p][b] = AW'(b);
              1: rd_vec[p][b] = AW'(NB - 1 - b);
              2: rd_vec[p][b] = AW'((b * 3 + p) % NE);
              3: rd_vec[p][b] = (((b >> 2) ^ b) & 1) != 0 ? AW'(5) : AW'(22);
              4: rd_vec[p][b] = AW'(p * 7 + 1);
              default: rd_vec[p][b] = r[AW-1:0];
            endcase
          end
        end
        step("R5_R7 gather");
      end
    end

    // R6: pointer entries with junk upper bits
    clear_in();
    wr_en = '1; wr_row = AW'(20);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] r;
      r = rnd();
      wr_data[b] = {r[2:0], AW'((b * 3 + 1) % NE)};
    end
    step("R6 setup");
    wr_row = AW'(4);
    for (int b = 0; b < NB; b++) wr_data[b] = {3'b111, AW'(NB - 1 - b)};
    step("R6 setup");
    clear_in();
    for (int w = 0; w < 4; w++) begin
      rd_en = '1; rd_mode = {2'd2, 2'd2, 2'd2}; rd_width = {2'(w), 2'(w), 2'(w)};
      rd_row[0] = AW'(20); rd_row[1] = AW'(4); rd_row[2] = AW'(20);
      step("R6 ptr read");
    end
    // R6: write scatter through pointer entry 20 (may hit entry 20 itself)
    clear_in();
    wr_en = '1; wr_mode = 2'd2; wr_row = AW'(20); rand_wdata();
    step("R6 ptr write");
    readback_all("R6 ptr readback");

    // R5/R7: scatter writes in 16- and 32-bit lanes
    clear_in();
    for (int w = 1; w < 3; w++) begin
      wr_en = '1; wr_mode = 2'd1; wr_width = 2'(w); rand_wdata();
      for (int b = 0; b < NB; b++) wr_vec[b] = AW'((b * 7 + w) % NE);
      step("R5_R7 scatter");
    end
    readback_all("R5_R7 scatter readback");

    // R8: partial read enables
    clear_in();
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < NRD; p++) begin
        logic [31:0] r;
        r = rnd();
        rd_en[p] = (i == 0) ? '0 : r;
        rd_row[p] = AW'(r >> 7);
      end
      step("R8 read enables");
    end

    // R9: partial write enables
    clear_in();
    for (int i = 0; i < 6; i++) begin
      logic [31:0] r;
      r = rnd();
      wr_en = (i == 0) ? 32'hA5A5_0F0F : r;
      wr_row = AW'(i * 5 + 1); rand_wdata();
      row_reads(i, i + 1, i * 5 + 1);
      step("R9 write enables");
    end
    readback_all("R9 readback");

    // R10: blend masks
    clear_in();
    for (int i = 0; i < 12; i++) begin
      for (int p = 0; p < NRD; p++) begin
        logic [31:0] r;
        r = rnd();
        rd_mode[p] = 2'd3;
        rd_row[p]  = AW'(r);
        rd_alt[p]  = AW'(r >> 5);
        rd_en[p]   = (i < 8) ? '1 : rnd();
        case (i % 4)
          0: rd_mask[p] = '0;
          1: rd_mask[p] = '1;
          2: rd_mask[p] = 32'h0F0F_F0F0;
          default: rd_mask[p] = rnd();
        endcase
      end
      step("R10 blend");
    end

    // R3 then R2: same-cycle write and read of one row, then read again
    clear_in();
    for (int i = 0; i < 4; i++) begin
      wr_en = '1; wr_mode = 2'd0; wr_row = AW'(9 + i); rand_wdata();
      row_reads(9 + i, 9 + i, 9 + i);
      step("R3 read-before-write");
      wr_en = '0;
      step("R2 read after write");
    end

    // R11: write mode 3 acts as row write
    clear_in();
    wr_en = '1; wr_mode = 2'd3; wr_row = AW'(17); rand_wdata();
    for (int b = 0; b < NB; b++) wr_vec[b] = AW'(b);
    step("R11 write mode 3");
    clear_in();
    row_reads(17, 0, 31);
    step("R11 readback");

    // R1/R3: all ports and write in random modes together
    for (int i = 0; i < 300; i++) begin
      for (int p = 0; p < NRD; p++) begin
        logic [31:0] r;
        r = rnd();
        rd_mode[p] = r[1:0]; rd_width[p] = r[3:2];
        rd_row[p] = r[8:4]; rd_alt[p] = r[13:9];
        rd_en[p] = (r[31:30] == 2'b00) ? rnd() : '1;
        rd_mask[p] = rnd();
        for (int b = 0; b < NB; b++) begin
          logic [31:0] q;
          q = rnd();
          rd_vec[p][b] = q[AW-1:0];
        end
      end
      begin
        logic [31:0] r;
        r = rnd();
        wr_mode = r[1:0]; wr_width = r[3:2]; wr_row = r[8:4];
        wr_en = (r[31:29] == 3'b000) ? '0 : rnd();
        for (int b = 0; b < NB; b++) begin
          logic [31:0] q;
          q = rnd();
          wr_vec[b] = q[AW-1:0];
        end
        rand_wdata();
      end
      step("R1_R3 mixed");
    end
    readback_all("R1 final readback");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule